// File: doc/BRIEF.md
# Printer Port Register Block

This block sits on the host side of a standard printer port. It presents three byte-wide registers at offsets 0, 1 and 2 on a simple synchronous read/write bus. Offset 0 holds outgoing data, offset 1 reports the peripheral's status lines, and offset 2 holds the handshake outputs and two internal mode bits.

The block drives eight data lines with a shared output enable. It pulls four open-drain handshake lines low or releases them, and it samples five status lines. Several lines are inverted in hardware, and the block applies those inversions. A direction bit turns the data lines around so that software can read bytes from the peripheral. The acknowledge line passes through a synchronizer. Its rising edge can latch an interrupt, and a status read clears it.

Top module: `printer_port_regs`

## Requirements
- R1: With control bit 5 at 0, a write to offset 0 drives the byte onto `pd_out` with `pd_oe` high on the next cycle, and a read of offset 0 returns the last byte written.
- R2: With control bit 5 at 1, `pd_oe` is low and a read of offset 0 returns `pd_in`. A byte written in this state is stored, and it appears on `pd_out` with `pd_oe` high once bit 5 is cleared.
- R3: A write to offset 1 changes neither the data register nor the control register.
- R4: A read of offset 1 returns bit 7 as the inverse of `busy_pin`. It returns bit 6 as `ack_n_pin`, bit 5 as `paper_out_pin`, bit 4 as `select_pin` and bit 3 as `error_pin`. Bits 1:0 read 0.
- R5: Control bits 5:4 read back as written. Written values in bits 7:6 are discarded, and those bits read 0.
- R6: The open-drain drives are set as follows. `ctl_pull_low[0]` equals control bit 0 (strobe). `ctl_pull_low[1]` equals bit 1 (auto feed). `ctl_pull_low[2]` equals the inverse of bit 2 (initialize). `ctl_pull_low[3]` equals bit 3 (select printer). Control value 0x04 therefore releases all four lines.
- R7: A read of offset 2 returns bits 3:0 from the line levels `ctl_level`. Bits 0, 1 and 3 are inverted, and bit 2 is taken as is.
- R8: While control bit 4 is 1, a rising edge on `ack_n_pin` sets a pending interrupt within three clock edges. A falling edge does not set it. While bit 4 is 0, no edge sets it. Status bit 2 reads 0 while an interrupt is pending and 1 otherwise.
- R9: A read of offset 1 clears the pending interrupt. `irq` is high exactly while an interrupt is pending and control bit 4 is 1.
- R10: After reset the data register is 0x00, the control register reads 0x04 with the lines released, no interrupt is pending and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; a read of offset 1 clears the pending interrupt |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| pd_out | output | 8 | Data line drive value |
| pd_oe | output | 1 | Data line output enable |
| pd_in | input | 8 | Data line levels |
| ctl_pull_low | output | 4 | Open-drain pull-down per handshake line |
| ctl_level | input | 4 | Handshake line levels |
| busy_pin | input | 1 | Busy line |
| ack_n_pin | input | 1 | Active-low acknowledge line |
| paper_out_pin | input | 1 | Paper out line |
| select_pin | input | 1 | Select line |
| error_pin | input | 1 | Error line |
| irq | output | 1 | Interrupt request |

## Verification
The data path is tested in both directions. Several byte patterns are written in forward mode. In reverse mode, the line values are distinct from the stored byte, which shows whether a read returns the lines or the register. Walking a single level through each handshake line and each status line separates the inverted bits from the plain ones. Acknowledge edges are applied in both polarities, with the enable bit both set and cleared, to tell the edge sense and the gating apart. A read-to-clear while the enable is off shows whether the pending flag is kept separate from the request output.

// File: rtl/printer_port_regs.sv
module printer_port_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic [7:0] pd_out,
  output logic       pd_oe,
  input  logic [7:0] pd_in,
  output logic [3:0] ctl_pull_low,
  input  logic [3:0] ctl_level,
  input  logic       busy_pin,
  input  logic       ack_n_pin,
  input  logic       paper_out_pin,
  input  logic       select_pin,
  input  logic       error_pin,
  output logic       irq
);

  localparam logic [1:0] OFS_DATA = 2'd0;
  localparam logic [1:0] OFS_STAT = 2'd1;
  localparam logic [1:0] OFS_CTRL = 2'd2;

  logic [7:0] data_q;
  logic [5:0] ctrl_q;
  logic [2:0] ack_sync;
  logic       pend_q;
  logic       ack_rise;
  logic       stat_rd;

  assign ack_rise = ack_sync[1] & ~ack_sync[2];
  assign stat_rd  = bus_rd && bus_addr == OFS_STAT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= 8'h00;
      ctrl_q <= 6'h04;
    end else if (bus_wr) begin
      if (bus_addr == OFS_DATA) data_q <= bus_wdata;
      if (bus_addr == OFS_CTRL) ctrl_q <= bus_wdata[5:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_sync <= 3'b111;
      pend_q   <= 1'b0;
    end else begin
      ack_sync <= {ack_sync[1:0], ack_n_pin};
      if (ctrl_q[4] && ack_rise) pend_q <= 1'b1;
      else if (stat_rd)          pend_q <= 1'b0;
    end
  end

  assign pd_out       = data_q;
  assign pd_oe        = ~ctrl_q[5];
  assign ctl_pull_low = {ctrl_q[3], ~ctrl_q[2], ctrl_q[1], ctrl_q[0]};
  assign irq          = pend_q & ctrl_q[4];

  always_comb begin
    unique case (bus_addr)
      OFS_DATA: bus_rdata = ctrl_q[5] ? pd_in : data_q;
      OFS_STAT: bus_rdata = {~busy_pin, ack_n_pin, paper_out_pin, select_pin,
                             error_pin, ~pend_q, 2'b00};
      OFS_CTRL: bus_rdata = {2'b00, ctrl_q[5:4], ~ctl_level[3], ctl_level[2],
                             ~ctl_level[1], ~ctl_level[0]};
      default:  bus_rdata = 8'h00;
    endcase
  end

  AST_FWD_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_DATA && pd_oe) |=> (pd_out == $past(bus_wdata) && pd_oe)); // R1
  AST_REV_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_CTRL && bus_wdata[5]) |=> !pd_oe); // R2
  AST_STAT_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_STAT) |=> ($stable(pd_out) && $stable(pd_oe) && $stable(ctl_pull_low))); // R3
  AST_CTRL_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_CTRL) |-> (bus_rdata[7:6] == 2'b00)); // R5
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !ack_rise) |=> !irq); // R9
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !bus_rdata[2] || bus_addr != OFS_STAT); // R8

endmodule

// File: tb/printer_port_regs_tb.sv
module printer_port_regs_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic [7:0] pd_out;
  logic       pd_oe;
  logic [7:0] pd_in = 8'h00;
  logic [3:0] ctl_pull_low;
  logic [3:0] ext_ctl = 4'hF;
  logic [3:0] ctl_level;
  logic       busy_pin = 0, ack_n_pin = 1, paper_out_pin = 0, select_pin = 0, error_pin = 0;
  logic       irq;
  int checks = 0, failures = 0;
  logic [7:0] rv;

  always #2 clk = ~clk;

  assign ctl_level = ext_ctl & ~ctl_pull_low;

  printer_port_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pd_out(pd_out), .pd_oe(pd_oe),
    .pd_in(pd_in), .ctl_pull_low(ctl_pull_low), .ctl_level(ctl_level),
    .busy_pin(busy_pin), .ack_n_pin(ack_n_pin), .paper_out_pin(paper_out_pin),
    .select_pin(select_pin), .error_pin(error_pin), .irq(irq));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rd(2'd0, rv); chk("R10 data", rv, 8'h00);
    rd(2'd2, rv); chk("R10 ctrl", rv, 8'h04);
    chk("R10 pulls", {4'h0, ctl_pull_low}, 8'h00);
    chk("R10 irq", {7'h0, irq}, 8'h00);
    rd(2'd1, rv); chk("R10 status bit2", {7'h0, rv[2]}, 8'h01);
  endtask

  task automatic t_forward;
    foreach (pat[i]) begin
      wr(2'd0, pat[i]);
      chk("R1 pins", pd_out, pat[i]);
      chk("R1 oe", {7'h0, pd_oe}, 8'h01);
      rd(2'd0, rv); chk("R1 readback", rv, pat[i]);
    end
  endtask
  logic [7:0] pat [4] = '{8'hA5, 8'h5A, 8'hFF, 8'h01};

  task automatic t_reverse;
    wr(2'd2, 8'h24);
    chk("R2 oe low", {7'h0, pd_oe}, 8'h00);
    pd_in = 8'h3C;
    rd(2'd0, rv); chk("R2 read pins", rv, 8'h3C);
    wr(2'd0, 8'hC3);
    rd(2'd0, rv); chk("R2 still pins", rv, 8'h3C);
    wr(2'd2, 8'h04);
    chk("R2 stored byte out", pd_out, 8'hC3);
    chk("R2 oe back", {7'h0, pd_oe}, 8'h01);
  endtask

  task automatic t_status_ro;
    wr(2'd1, 8'hFF);
    rd(2'd0, rv); chk("R3 data kept", rv, 8'hC3);
    rd(2'd2, rv); chk("R3 ctrl kept", rv, 8'h04);
  endtask

  task automatic t_status_bits;
    busy_pin = 1; ack_n_pin = 1; paper_out_pin = 0; select_pin = 1; error_pin = 0;
    rd(2'd1, rv); chk("R4 pattern a", rv, 8'b0101_0100);
    busy_pin = 0; paper_out_pin = 1; select_pin = 0; error_pin = 1;
    rd(2'd1, rv); chk("R4 pattern b", rv, 8'b1110_1100);
    busy_pin = 0; paper_out_pin = 0; error_pin = 0;
  endtask

  task automatic t_ctrl;
    wr(2'd2, 8'hF4);
    rd(2'd2, rv); chk("R5 top ignored", rv, 8'h34);
    chk("R6 released", {4'h0, ctl_pull_low}, 8'h00);
    wr(2'd2, 8'h0B);
    chk("R6 all pulled", {4'h0, ctl_pull_low}, 8'h0F);
    rd(2'd2, rv); chk("R7 reads levels", rv, 8'h0B);
    wr(2'd2, 8'h04);
    for (int b = 0; b < 4; b++) begin
      ext_ctl = ~(4'b1 << b);
      rd(2'd2, rv); chk("R7 ext pull", rv, 8'h04 ^ (8'h01 << b));
    end
    ext_ctl = 4'hF;
  endtask

  task automatic t_irq;
    wr(2'd2, 8'h14);
    ack_n_pin = 0; wait_cyc(4);
    chk("R8 falling no irq", {7'h0, irq}, 8'h00);
    ack_n_pin = 1; wait_cyc(3);
    chk("R8 rising irq", {7'h0, irq}, 8'h01);
    rd(2'd1, rv); chk("R8 pending bit2", {7'h0, rv[2]}, 8'h00);
    chk("R9 cleared", {7'h0, irq}, 8'h00);
    rd(2'd1, rv); chk("R9 bit2 after clear", {7'h0, rv[2]}, 8'h01);
    ack_n_pin = 0; wait_cyc(4); ack_n_pin = 1; wait_cyc(4);
    wr(2'd2, 8'h04);
    chk("R9 gated off", {7'h0, irq}, 8'h00);
    wr(2'd2, 8'h14);
    chk("R9 regated on", {7'h0, irq}, 8'h01);
    rd(2'd1, rv);
    wr(2'd2, 8'h04);
    ack_n_pin = 0; wait_cyc(4); ack_n_pin = 1; wait_cyc(4);
    rd(2'd1, rv); chk("R8 disabled no set", {7'h0, rv[2]}, 8'h01);
  endtask

  initial begin
    wait_cyc(3); rst_n = 1; wait_cyc(1);
    t_reset;
    t_forward;
    t_reverse;
    t_status_ro;
    t_status_bits;
    t_ctrl;
    t_irq;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule